// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Protocol Engine

This block is the bus-facing front end of a serial byte memory. It watches a two-wire bus (clock line and open-drain data line) with the system clock, recognises bus framing events, and decodes the first byte of each transfer as a selector byte. That byte carries a fixed 4-bit device code, three chip-select bits that must agree with strap pins, and a direction bit. Once selected, the engine acknowledges each received byte, loads the second byte of a write into an address pointer, and hands the bytes after it to the memory as single-cycle write strobes. For reads it fetches bytes from the memory at the pointer and shifts them onto the bus.

The data line is only ever pulled low through an enable output. The engine never drives it high. While the memory's write unit reports a programming cycle in progress, the engine stays silent on the bus. A framing event seen at any point abandons the byte in progress.

Top module: `tws_mem_slave`

## Requirements
- R1: A falling data line while the clock line is high (Start) begins a new selector byte. A rising data line while the clock line is high (Stop) returns to idle and releases the data line.
- R2: The selector byte is acknowledged only when bits 7..4 equal the device code 4'b1010 and bits 3..1 equal `cs_pins_i`. Bit 0 selects read (1) or write (0). An unmatched selector is not acknowledged, and the engine ignores the bus until the next Start.
- R3: An acknowledge pulls the data line low from the clock fall that ends the eighth bit to the clock fall that ends the ninth bit. The pull-down enable changes only while the clock line is low, except on a Start or Stop.
- R4: While `wr_busy_i` is high, no byte is acknowledged and no write strobe is issued.
- R5: In a write, the byte after the selector is acknowledged and loaded into the address pointer, which is visible on `rd_addr_o`.
- R6: Each further write byte is acknowledged and issued as a one-cycle `wr_en_o` with the pointer address. The low 4 bits of the pointer then increment modulo 16, and the upper bits hold.
- R7: In a read, the byte at the pointer is shifted out MSB first. The first bit starts at the clock fall that ends the selector acknowledge, and a 0 bit is sent by pulling the line low.
- R8: When the master acknowledges a read byte (data low on the ninth clock), the pointer increments across the full 8-bit range and the next byte follows. When the master does not acknowledge, the line is released until the next Start.
- R9: A Start inside a partly received byte abandons that byte without a write strobe, and the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pd_o | output | 1 | Pull-down enable for the data line |
| cs_pins_i | input | 3 | Chip-select strap levels |
| wr_busy_i | input | 1 | Write unit busy with a programming cycle |
| wr_en_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 8 | Write address |
| wr_data_o | output | 8 | Write data |
| rd_addr_o | output | 8 | Address pointer, used as the read address |
| rd_data_i | input | 8 | Memory byte at `rd_addr_o` |

## Verification
The bench targets three boundaries. The first is a page write that runs past the top of a 16-byte page: a design that carried into bit 4 would write the fifth byte to the next page. The second is a sequential read that crosses the same boundary, where a design that reused the page wrap would return to the start of the page. The third covers selectors with a wrong chip-select field, a wrong device code, or a busy write unit; a careless design would acknowledge these or strobe data from them. A Start placed in the middle of a data byte checks that no half byte reaches the memory and that the pointer is unchanged.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_SEL, PH_ADDR, PH_WDATA, PH_RDATA, PH_SKIP
  } phase_t;

  // selector byte decode: device code plus strap pins
  function automatic logic sel_hit(input logic [7:0] b, input logic [3:0] code,
                                   input logic [2:0] pins);
    return (b[7:4] == code) && (b[3:1] == pins);
  endfunction

  // increment only the low pb bits, upper bits held
  function automatic logic [15:0] page_step(input logic [15:0] p, input int unsigned pb);
    logic [15:0] m;
    m = (16'(1) << pb) - 16'(1);
    return (p & ~m) | ((p + 16'(1)) & m);
  endfunction

  function automatic logic [15:0] lin_step(input logic [15:0] p);
    return p + 16'(1);
  endfunction
endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_prev
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_prev <= 1'b1;
    else q_prev <= chain[STAGES-1];
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tws_bus_events.sv
module tws_bus_events #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_prev, sda_prev;

  tws_line_sync #(.STAGES(STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_lvl), .q_prev(scl_prev));
  tws_line_sync #(.STAGES(STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_lvl), .q_prev(sda_prev));

  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/tws_addr_ptr.sv
module tws_addr_ptr
  import tws_pkg::*;
#(
  parameter int AW = 8,
  parameter int PB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          page_inc,
  input  logic          lin_inc,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr <= '0;
    else if (load)     ptr <= load_val;
    else if (page_inc) ptr <= AW'(page_step(16'(ptr), PB));
    else if (lin_inc)  ptr <= AW'(lin_step(16'(ptr)));
  end
endmodule

// File: rtl/tws_mem_slave.sv
module tws_mem_slave
  import tws_pkg::*;
#(
  parameter int         AW       = 8,
  parameter int         PB       = 4,
  parameter int         STAGES   = 2,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pd_o,
  input  logic [2:0]    cs_pins_i,
  input  logic          wr_busy_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i
);
  localparam int CW = 4;
  localparam logic [CW-1:0] LAST_BIT = CW'(8);
  localparam logic [CW-1:0] ACK_BIT  = CW'(9);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [7:0]    rx_sh, tx_sh;
  logic          pd_q, m_ack;

  // named internal events
  logic rx_phase, byte_end, ack_go, nack_evt, ptr_load, wr_go, rd_inc, sel_ok;

  tws_bus_events #(.STAGES(STAGES)) u_ev (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt));

  assign rx_phase = (phase == PH_SEL) || (phase == PH_ADDR) || (phase == PH_WDATA);
  assign byte_end = rx_phase && scl_fall && (cnt == LAST_BIT) && !start_evt && !stop_evt;
  assign sel_ok   = (phase != PH_SEL) || sel_hit(rx_sh, DEV_CODE, cs_pins_i);
  assign ack_go   = byte_end && sel_ok && !wr_busy_i;
  assign ptr_load = ack_go && (phase == PH_ADDR);
  assign wr_go    = ack_go && (phase == PH_WDATA);
  assign rd_inc   = (phase == PH_RDATA) && scl_rise && (cnt == LAST_BIT) && !sda_lvl
                    && !start_evt && !stop_evt;
  assign nack_evt = (phase == PH_RDATA) && scl_fall && (cnt == ACK_BIT) && !m_ack
                    && !start_evt && !stop_evt;

  tws_addr_ptr #(.AW(AW), .PB(PB)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(rx_sh[AW-1:0]),
    .page_inc(wr_go), .lin_inc(rd_inc), .ptr(rd_addr_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      rx_sh <= '0;
      tx_sh <= '0;
      pd_q  <= 1'b0;
      m_ack <= 1'b0;
    end else if (start_evt) begin
      phase <= PH_SEL;
      cnt   <= '0;
      pd_q  <= 1'b0;
    end else if (stop_evt) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      pd_q  <= 1'b0;
    end else begin
      unique case (phase)
        PH_SEL, PH_ADDR, PH_WDATA: begin
          if (scl_rise) begin
            if (cnt < LAST_BIT) begin
              rx_sh <= {rx_sh[6:0], sda_lvl};
              cnt   <= cnt + CW'(1);
            end else if (cnt == LAST_BIT) begin
              cnt <= ACK_BIT;
            end
          end else if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              if (ack_go) pd_q <= 1'b1;
              else        phase <= PH_SKIP;
            end else if (cnt == ACK_BIT) begin
              pd_q <= 1'b0;
              cnt  <= '0;
              if (phase == PH_SEL) begin
                if (rx_sh[0]) begin
                  phase <= PH_RDATA;
                  tx_sh <= rd_data_i;
                  pd_q  <= ~rd_data_i[7];
                end else begin
                  phase <= PH_ADDR;
                end
              end else begin
                phase <= PH_WDATA;
              end
            end
          end
        end
        PH_RDATA: begin
          if (scl_rise) begin
            if (cnt < LAST_BIT) cnt <= cnt + CW'(1);
            else if (cnt == LAST_BIT) begin
              cnt   <= ACK_BIT;
              m_ack <= ~sda_lvl;
            end
          end else if (scl_fall) begin
            if (cnt > CW'(0) && cnt < LAST_BIT) begin
              tx_sh <= {tx_sh[6:0], 1'b0};
              pd_q  <= ~tx_sh[6];
            end else if (cnt == LAST_BIT) begin
              pd_q <= 1'b0;
            end else if (cnt == ACK_BIT) begin
              cnt <= '0;
              if (m_ack) begin
                tx_sh <= rd_data_i;
                pd_q  <= ~rd_data_i[7];
              end else begin
                phase <= PH_SKIP;
                pd_q  <= 1'b0;
              end
            end
          end
        end
        default: begin
          pd_q <= 1'b0;
          cnt  <= '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= wr_go;
      if (wr_go) begin
        wr_addr_o <= rd_addr_o;
        wr_data_o <= rx_sh;
      end
    end
  end

  assign sda_pd_o = pd_q;
endmodule

// File: rtl/tws_mem_slave_chk.sv
module tws_mem_slave_chk #(
  parameter int AW = 8,
  parameter int PB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_lvl,
  input logic          start_evt,
  input logic          stop_evt,
  input logic          nack_evt,
  input logic          ack_go,
  input logic          sda_pd_o,
  input logic          wr_busy_i,
  input logic          wr_en_o,
  input logic [AW-1:0] wr_addr_o,
  input logic [AW-1:0] rd_addr_o
);
  assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pd_o);

  assert_start_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_pd_o);

  assert_pd_low_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pd_o != $past(sda_pd_o)) && !$past(start_evt) && !$past(stop_evt)
      |-> !$past(scl_lvl));

  assert_ack_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_go |=> sda_pd_o);

  assert_busy_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy_i && $past(wr_busy_i) |-> !wr_en_o);

  assert_page_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (rd_addr_o[AW-1:PB] == wr_addr_o[AW-1:PB]) &&
                (rd_addr_o[PB-1:0] == wr_addr_o[PB-1:0] + 1'b1));

  assert_write_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);

  assert_nack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nack_evt |=> !sda_pd_o);
endmodule

bind tws_mem_slave tws_mem_slave_chk #(.AW(AW), .PB(PB)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_evt(start_evt),
  .stop_evt(stop_evt), .nack_evt(nack_evt), .ack_go(ack_go), .sda_pd_o(sda_pd_o),
  .wr_busy_i(wr_busy_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
  .rd_addr_o(rd_addr_o));

// File: tb/tws_mem_slave_bench.sv
module tws_mem_slave_bench;
  localparam int Q = 10;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_pd_o, wr_en_o, wr_busy_i = 1'b0;
  logic [2:0] cs_pins_i = 3'b101;
  logic [7:0] wr_addr_o, wr_data_o, rd_addr_o, rd_data_i;
  wire  sda_bus = sda_m & ~sda_pd_o;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [15:0] wq[$];
  int   exp_ptr = 0;
  int   n_cmp = 0, n_bad = 0;
  bit   done = 0;

  tws_mem_slave u_tws_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_pd_o(sda_pd_o),
    .cs_pins_i(cs_pins_i), .wr_busy_i(wr_busy_i), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i));

  always #2 clk = ~clk;
  assign rd_data_i = mem[rd_addr_o];

  initial for (int i = 0; i < 256; i++) begin
    mem[i] = 8'(i) ^ 8'h5A;
    exp_mem[i] = 8'(i) ^ 8'h5A;
  end

  always @(posedge clk) if (wr_en_o) mem[wr_addr_o] <= wr_data_o;

  task automatic check(input int act, input int exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of write strobes against the model queue (R6)
  always @(negedge clk) if (rst_n && wr_en_o) begin
    if (wq.size() == 0) check(1, 0, "R6 unexpected write strobe");
    else begin
      logic [15:0] e;
      e = wq.pop_front();
      check({wr_addr_o, wr_data_o}, e, "R6 write strobe addr/data");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_clk(input logic b, output logic s);
    sda_m = b; cyc(Q);
    scl = 1'b1; cyc(Q);
    s = sda_bus; cyc(Q);
    scl = 1'b0; cyc(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; cyc(Q);
    scl = 1'b1; cyc(2*Q);
    sda_m = 1'b0; cyc(2*Q);
    scl = 1'b0; cyc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; cyc(Q);
    scl = 1'b1; cyc(2*Q);
    sda_m = 1'b1; cyc(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_clk(b[i], s);
      check(s, b[i], {tag, " line free during data"});
    end
    bit_clk(1'b1, s);
    check(s, exp_ack ? 0 : 1, {tag, " ack bit"});
  endtask

  task automatic recv_byte(input logic [7:0] e, input bit give_ack, input string tag);
    logic s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      bit_clk(1'b1, s);
      got[i] = s;
    end
    check(got, e, tag);
    bit_clk(~give_ack, s);
  endtask

  task automatic wr_byte_exp(input logic [7:0] d);
    wq.push_back({8'(exp_ptr), d});
    exp_mem[exp_ptr] = d;
    exp_ptr = (exp_ptr & 8'hF0) | ((exp_ptr + 1) & 8'h0F);
    send_byte(d, 1, "R6 data byte");
  endtask

  initial begin
    logic s;
    cyc(5);
    check(sda_pd_o, 0, "R1 reset line released");
    check(wr_en_o, 0, "R6 reset no strobe");
    check(rd_addr_o, 0, "R5 reset pointer");
    rst_n = 1'b1;
    cyc(10);

    // page write running past the top of the page
    bus_start();
    send_byte(8'hAA, 1, "R2 selector match write");
    send_byte(8'h3C, 1, "R5 address byte");
    exp_ptr = 8'h3C;
    wr_byte_exp(8'h11); wr_byte_exp(8'h22); wr_byte_exp(8'h33);
    wr_byte_exp(8'h44); wr_byte_exp(8'h55);
    bus_stop();
    cyc(Q);
    check(wq.size(), 0, "R6 all writes strobed");
    check(rd_addr_o, 8'h31, "R6 pointer wrapped in page");
    check(sda_pd_o, 0, "R1 released after stop");

    // address only, then current-address read across page edge
    bus_start();
    send_byte(8'hAA, 1, "R2 selector write");
    send_byte(8'h3E, 1, "R5 address byte");
    bus_stop();
    cyc(Q);
    check(rd_addr_o, 8'h3E, "R5 pointer loaded");
    exp_ptr = 8'h3E;
    bus_start();
    send_byte(8'hAB, 1, "R2 selector read");
    recv_byte(exp_mem[8'h3E], 1, "R7 read first byte");
    recv_byte(exp_mem[8'h3F], 1, "R8 read after master ack");
    recv_byte(exp_mem[8'h40], 0, "R8 read crosses page");
    check(sda_pd_o, 0, "R8 released after nack");
    bit_clk(1'b1, s);
    check(s, 1, "R8 silent after nack");
    bus_stop();
    cyc(Q);
    check(rd_addr_o, 8'h40, "R8 full-range increment");

    // wrong chip-select and wrong code
    bus_start();
    send_byte(8'hA8, 0, "R2 wrong chip-select");
    send_byte(8'h77, 0, "R2 ignored after mismatch");
    bus_stop();
    bus_start();
    send_byte(8'hBA, 0, "R2 wrong device code");
    send_byte(8'h66, 0, "R2 ignored after bad code");
    bus_stop();
    cyc(Q);
    check(rd_addr_o, 8'h40, "R2 pointer untouched");

    // busy write unit
    wr_busy_i = 1'b1;
    bus_start();
    send_byte(8'hAA, 0, "R4 busy no ack");
    send_byte(8'h05, 0, "R4 busy stays silent");
    bus_stop();
    cyc(Q);
    check(rd_addr_o, 8'h40, "R4 pointer untouched");
    wr_busy_i = 1'b0;

    // Start in the middle of a data byte
    bus_start();
    send_byte(8'hAA, 1, "R9 selector");
    send_byte(8'h10, 1, "R9 address byte");
    for (int i = 0; i < 4; i++) bit_clk(1'b0, s);
    bus_start();
    send_byte(8'hAB, 1, "R9 selector read after abort");
    recv_byte(exp_mem[8'h10], 0, "R9 no partial write, pointer kept");
    bus_stop();
    cyc(Q);
    check(wq.size(), 0, "R9 no stray strobe");
    check(rd_addr_o, 8'h10, "R9 pointer kept");

    // single write then readback of page start
    bus_start();
    send_byte(8'hAA, 1, "R1 new transfer");
    send_byte(8'h30, 1, "R5 address");
    exp_ptr = 8'h30;
    wr_byte_exp(8'hC3);
    bus_stop();
    cyc(2*Q);
    bus_start();
    send_byte(8'hAA, 1, "R5 selector");
    send_byte(8'h30, 1, "R5 address");
    bus_start();
    send_byte(8'hAB, 1, "R7 selector read");
    recv_byte(exp_mem[8'h30], 1, "R7 read written byte");
    recv_byte(exp_mem[8'h31], 0, "R7 read wrapped byte");
    bus_stop();
    cyc(Q);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule